// File: doc/BRIEF.md
# Sign-Magnitude 48-bit Floating Adder

This block adds or subtracts two 48-bit floating-point words in a non-IEEE format. Each word carries a sign bit, an 11-bit unsigned exponent offset by 1024, and a 36-bit fraction that is an explicit value in [0, 1) with no implied leading one. Operands and an add/subtract select enter on a valid/ready handshake. The block then runs a fixed three-step sequence: capture, align-and-combine, normalize. It returns the packed result together with a one-cycle done pulse.

Back-pressure works as follows. The block raises `in_ready` only while idle. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. While the block is busy, the source must hold its operands steady. Whatever is on the operand pins during that time is ignored. The block has no output-side stall: `result` stays valid from the done pulse until the next done pulse, and the consumer samples it while `done` is high.

Top module: `fadd48`

## Requirements
- R1: `in_ready` is high whenever the block is idle and goes low for the two cycles that follow an accepting edge. Operand and select changes while `in_ready` is low have no effect on the pending result. A word held valid through the busy period is accepted once `in_ready` returns.
- R2: `done` rises at the third rising edge counted from the accepting edge (the accepting edge being the first) and stays high for exactly one cycle. `result` does not change between done pulses.
- R3: Words are packed with the sign in bit 47, the exponent in bits 46:36 and the fraction in bits 35:0. The value is fraction × 2^(exponent − 1024), and fraction bit 35 has weight 1/2.
- R4: With `op_sub` = 0 the result is a + b. With `op_sub` = 1 the result is a − b, formed by inverting the sign of b.
- R5: The operand with the smaller exponent has its fraction shifted right by the exponent difference, and the shifted-out bits are dropped. A difference of 36 or more makes that operand contribute zero.
- R6: A carry out of the fraction sum shifts the fraction right by one, with truncation, and raises the exponent by one.
- R7: After cancellation, the fraction is shifted left until bit 35 is set, and the exponent is lowered by the same count.
- R8: An exact zero result is returned as all 48 bits zero, which is a positive sign.
- R9: A carry when the larger exponent is already 2047 saturates the result to exponent 2047 and an all-ones fraction, keeping the sign.
- R10: If normalizing would need a left shift larger than the larger exponent, the result is flushed to +0. A shift equal to the exponent gives exponent 0.
- R11: The result sign is the sign of the operand whose aligned magnitude is larger, with b's sign taken after the subtract inversion.
- R12: Every nonzero result has fraction bit 35 set, including when the inputs are not normalized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers operands |
| in_ready | output | 1 | Block is idle and will take operands |
| op_sub | input | 1 | 1 = subtract b from a, 0 = add |
| opnd_a | input | 48 | First operand |
| opnd_b | input | 48 | Second operand |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 48 | Packed sum or difference |

## Verification
Each result comes three rising edges after acceptance, counting the accepting edge. The bench drives at falling edges and counts falling edges from the accepting edge. It expects `done` low at the first two and high at the third, and it reads `result` only at that third falling edge. The ready check is made at the falling edge just after acceptance. For the hold check, the bench samples `result` again one cycle after the pulse.

// File: rtl/fadd48_pkg.sv
package fadd48_pkg;
  localparam int unsigned DEF_EXP_W  = 11;
  localparam int unsigned DEF_FRAC_W = 36;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_NORM
  } fadd_state_e;
endpackage

// File: rtl/fadd48_lzc.sv
module fadd48_lzc #(
  parameter int unsigned W  = 36,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fadd48_align.sv
module fadd48_align #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 36
) (
  input  logic              sign_a,
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic              sign_b,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic [FRAC_W-1:0] frac_b,
  output logic              sum_sign,
  output logic [EXP_W-1:0]  sum_exp,
  output logic [FRAC_W:0]   sum_mag
);
  localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(FRAC_W);

  logic              a_big;
  logic              s_hi, s_lo;
  logic [EXP_W-1:0]  e_hi, e_lo, shamt;
  logic [FRAC_W-1:0] f_hi, f_lo, lo_al;

  always_comb begin
    a_big = (exp_a > exp_b) || ((exp_a == exp_b) && (frac_a >= frac_b));
    s_hi  = a_big ? sign_a : sign_b;
    s_lo  = a_big ? sign_b : sign_a;
    e_hi  = a_big ? exp_a  : exp_b;
    e_lo  = a_big ? exp_b  : exp_a;
    f_hi  = a_big ? frac_a : frac_b;
    f_lo  = a_big ? frac_b : frac_a;
    shamt = e_hi - e_lo;
    lo_al = (shamt >= SHIFT_LIM) ? '0 : (f_lo >> shamt);
    sum_exp = e_hi;
    if (s_hi == s_lo) begin
      sum_mag  = {1'b0, f_hi} + {1'b0, lo_al};
      sum_sign = s_hi;
    end else if (f_hi >= lo_al) begin
      sum_mag  = {1'b0, f_hi - lo_al};
      sum_sign = s_hi;
    end else begin
      sum_mag  = {1'b0, lo_al - f_hi};
      sum_sign = s_lo;
    end
  end
endmodule

// File: rtl/fadd48_norm.sv
module fadd48_norm #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 36
) (
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W:0]   in_mag,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac
);
  localparam int unsigned     CW      = $clog2(FRAC_W + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  logic [CW-1:0]  lz;
  logic [EXP_W:0] lz_x;

  fadd48_lzc #(.W(FRAC_W), .CW(CW)) u_lzc (
    .vec   (in_mag[FRAC_W-1:0]),
    .count (lz)
  );

  always_comb begin
    lz_x     = (EXP_W + 1)'(lz);
    out_sign = 1'b0;
    out_exp  = '0;
    out_frac = '0;
    if (in_mag[FRAC_W]) begin
      out_sign = in_sign;
      if (in_exp == EXP_MAX) begin
        out_exp  = EXP_MAX;
        out_frac = '1;
      end else begin
        out_exp  = in_exp + 1'b1;
        out_frac = in_mag[FRAC_W:1];
      end
    end else if ((lz != CW'(FRAC_W)) && (lz_x <= {1'b0, in_exp})) begin
      out_sign = in_sign;
      out_exp  = in_exp - lz_x[EXP_W-1:0];
      out_frac = in_mag[FRAC_W-1:0] << lz;
    end
  end
endmodule

// File: rtl/fadd48.sv
module fadd48
  import fadd48_pkg::*;
#(
  parameter int unsigned EXP_W  = DEF_EXP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  localparam int unsigned SGN = WORD_W - 1;

  fadd_state_e state_q;
  logic        accept;

  logic              sa_q, sb_q;
  logic [EXP_W-1:0]  ea_q, eb_q;
  logic [FRAC_W-1:0] fa_q, fb_q;

  logic              al_sign;
  logic [EXP_W-1:0]  al_exp;
  logic [FRAC_W:0]   al_mag;

  logic              mid_sign_q;
  logic [EXP_W-1:0]  mid_exp_q;
  logic [FRAC_W:0]   mid_mag_q;

  logic              nm_sign;
  logic [EXP_W-1:0]  nm_exp;
  logic [FRAC_W-1:0] nm_frac;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_ALIGN;
        ST_ALIGN: state_q <= ST_NORM;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= 1'b0; ea_q <= '0; fa_q <= '0;
      sb_q <= 1'b0; eb_q <= '0; fb_q <= '0;
    end else if (accept) begin
      sa_q <= opnd_a[SGN];
      ea_q <= opnd_a[SGN-1 -: EXP_W];
      fa_q <= opnd_a[FRAC_W-1:0];
      sb_q <= opnd_b[SGN] ^ op_sub;
      eb_q <= opnd_b[SGN-1 -: EXP_W];
      fb_q <= opnd_b[FRAC_W-1:0];
    end
  end

  fadd48_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sign_a   (sa_q),
    .exp_a    (ea_q),
    .frac_a   (fa_q),
    .sign_b   (sb_q),
    .exp_b    (eb_q),
    .frac_b   (fb_q),
    .sum_sign (al_sign),
    .sum_exp  (al_exp),
    .sum_mag  (al_mag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_sign_q <= 1'b0;
      mid_exp_q  <= '0;
      mid_mag_q  <= '0;
    end else if (state_q == ST_ALIGN) begin
      mid_sign_q <= al_sign;
      mid_exp_q  <= al_exp;
      mid_mag_q  <= al_mag;
    end
  end

  fadd48_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .in_sign  (mid_sign_q),
    .in_exp   (mid_exp_q),
    .in_mag   (mid_mag_q),
    .out_sign (nm_sign),
    .out_exp  (nm_exp),
    .out_frac (nm_frac)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= (state_q == ST_NORM);
      if (state_q == ST_NORM) result <= {nm_sign, nm_exp, nm_frac};
    end
  end
endmodule

// File: rtl/fadd48_chk.sv
module fadd48_chk #(
  parameter int unsigned FRAC_W = 36,
  parameter int unsigned WORD_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic [WORD_W-1:0] result
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  p_done_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc, 3) |-> done);

  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc, 3));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_zero_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result[FRAC_W-1:0] == '0)) |-> (result == '0));

  p_norm_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result != '0)) |-> result[FRAC_W-1]);
endmodule

bind fadd48 fadd48_chk #(.FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .result   (result)
);

// File: tb/test_fadd48.sv
module test_fadd48;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  function automatic logic [47:0] fp(input logic s, input int e, input logic [35:0] f);
    return {s, 11'(e), f};
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic        sub;
    logic [47:0] a;
    logic [47:0] b;
    logic [47:0] want;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R6: 0.5 + 0.5 carries into exponent
    '{4'd6,  1'b0, fp(0,1024,36'h800000000), fp(0,1024,36'h800000000), fp(0,1025,36'h800000000)},
    // R5: aligned add, then carry
    '{4'd5,  1'b0, fp(0,1025,36'hC00000000), fp(0,1024,36'h800000000), fp(0,1026,36'h800000000)},
    // R7: cancellation renormalizes
    '{4'd7,  1'b1, fp(0,1024,36'hC00000000), fp(0,1024,36'h800000000), fp(0,1023,36'h800000000)},
    // R11: larger subtrahend gives negative result
    '{4'd11, 1'b1, fp(0,1024,36'h800000000), fp(0,1024,36'hC00000000), fp(1,1023,36'h800000000)},
    // R8: exact cancellation is all-zero word
    '{4'd8,  1'b1, fp(0,1030,36'hC00000000), fp(0,1030,36'hC00000000), 48'h0},
    // R5: difference of 40 drops the smaller operand
    '{4'd5,  1'b0, fp(0,1100,36'h800000000), fp(0,1060,36'h800000000), fp(0,1100,36'h800000000)},
    // R5: truncated bit lost during alignment
    '{4'd5,  1'b0, fp(0,1024,36'h800000000), fp(0,1023,36'h800000001), fp(0,1024,36'hC00000000)},
    // R9: saturation at top exponent
    '{4'd9,  1'b0, fp(0,2047,36'hC00000000), fp(0,2047,36'hC00000000), fp(0,2047,36'hFFFFFFFFF)},
    // R10: needed shift exceeds exponent, flush
    '{4'd10, 1'b1, fp(0,2,36'h800000001),    fp(0,2,36'h800000000),    48'h0},
    // R10: shift equal to exponent lands on exponent 0
    '{4'd10, 1'b1, fp(0,1,36'hC00000000),    fp(0,1,36'h800000000),    fp(0,0,36'h800000000)},
    // R12: unnormalized input leaves normalized
    '{4'd12, 1'b0, fp(0,1024,36'h200000000), 48'h0,                    fp(0,1022,36'h800000000)},
    // R11: two negatives add to a negative
    '{4'd11, 1'b0, fp(1,1024,36'h800000000), fp(1,1024,36'h800000000), fp(1,1025,36'h800000000)},
    // R4: subtracting a negative adds
    '{4'd4,  1'b1, fp(0,1024,36'h800000000), fp(1,1024,36'h800000000), fp(0,1025,36'h800000000)},
    // R3: b larger exponent, sign from b after inversion
    '{4'd3,  1'b1, fp(0,1020,36'h800000000), fp(0,1024,36'h800000000), fp(1,1023,36'hF00000000)},
    // R4: plain add with b the larger
    '{4'd4,  1'b0, fp(0,1024,36'h800000000), fp(0,1026,36'hC00000000), fp(0,1026,36'hE00000000)}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [47:0] opnd_a = '0;
  logic [47:0] opnd_b = '0;
  logic        in_ready;
  logic        done;
  logic [47:0] result;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fadd48 i_fadd48 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .op_sub   (op_sub),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .done     (done),
    .result   (result)
  );

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Offers one word, returns the result and the falling-edge count to done.
  task automatic issue(input logic s, input logic [47:0] a, input logic [47:0] b,
                       output logic [47:0] r, output int lat);
    @(negedge clk);
    in_valid = 1'b1; op_sub = s; opnd_a = a; opnd_b = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    r = result;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [47:0] r;
    logic [47:0] first;
    int lat;
    repeat (3) @(negedge clk);
    // R1 R2: reset state
    check("R1 ready after reset", {47'h0, in_ready}, 48'h1);
    check("R2 done after reset", {47'h0, done}, 48'h0);
    check("R2 result after reset", result, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].sub, VEC[i].a, VEC[i].b, r, lat);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].want);
      check($sformatf("R2 latency vector %0d", i), 48'(lat), 48'(LAT));
    end

    // R1: busy back-pressure, inputs changed while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; op_sub = VEC[0].sub; opnd_a = VEC[0].a; opnd_b = VEC[0].b;
    check("R1 ready before accept", {47'h0, in_ready}, 48'h1);
    @(negedge clk);
    op_sub = VEC[2].sub; opnd_a = VEC[2].a; opnd_b = VEC[2].b;
    check("R1 ready low after accept", {47'h0, in_ready}, 48'h0);
    @(negedge clk);
    check("R1 ready low second cycle", {47'h0, in_ready}, 48'h0);
    check("R2 no early done", {47'h0, done}, 48'h0);
    @(negedge clk);
    check("R2 done due", {47'h0, done}, 48'h1);
    check("R1 first word result", result, VEC[0].want);
    check("R1 ready back", {47'h0, in_ready}, 48'h1);
    first = result;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 done single cycle", {47'h0, done}, 48'h0);
    check("R2 result held", result, first);
    @(negedge clk);
    check("R2 held during second op", result, first);
    @(negedge clk);
    check("R1 held word accepted", {47'h0, done}, 48'h1);
    check("R1 held word result", result, VEC[2].want);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule